// File: doc/BRIEF.md
# Double-Precision to Wide Fixed-Point Converter

This block turns one IEEE 754 binary64 value into a wide two's complement fixed-point number built from `NW` words of 64 bits. `KF` of those words hold the fraction and the remaining `NW-KF` hold the integer part. Because an integer sum of such numbers does not depend on the order of addition, a sum built from these words comes out the same in any order, on any machine. The mantissa is placed by a barrel shift driven by the exponent. No floating-point arithmetic is used.

A value is offered with `in_valid` while `in_ready` is high. The result appears on `out_words` together with a one-cycle `out_done` strobe and three exclusive flags: out of range, bits lost below the lowest fractional weight, and not a number or infinite. The parameter `SERIAL` selects the output variant. With `SERIAL=0`, all words are produced in one registered step. With `SERIAL=1`, one word is produced per cycle, from the least significant word upward, and a running "everything below is zero" flag supplies the negation carry.

Top module: `d2fx_conv`

## Requirements
- R1: During and after reset, `out_done`, all three flags and `out_words` are zero and `in_ready` is high.
- R2: For a positive finite input whose magnitude is below 2^(64*(NW-KF)-1), `out_words` holds floor(|x|*2^(64*KF)) as an unsigned number. Word 0 is in bits [64*NW-1:64*NW-64] and is the most significant word. Bit 64*NW-1 is the sign and is zero.
- R3: A finite input whose magnitude is 2^(64*(NW-KF)-1) or more sets `out_ovf` and gives all-zero words. With NW=3 and KF=2, 2^62 is in range and 2^63 is not.
- R4: If any significand bit has weight below 2^(-64*KF), `out_unf` is set and the truncated magnitude is still delivered. With KF=2, 2^-128 converts exactly to a value of 1, and 2^-129 gives zero with `out_unf` set.
- R5: A negative input gives the 64*NW-bit two's complement of the word vector that its magnitude would give. Adding the results for x and -x modulo 2^(64*NW) gives zero.
- R6: Positive and negative zero both give all-zero words with no flag set.
- R7: Subnormal inputs use an exponent of -1022 and no hidden bit. With KF=2, every subnormal underflows to zero with `out_unf` set.
- R8: NaN and both infinities set `out_inv` and give all-zero words. At most one of the three flags is set at any time.
- R9: If `in_valid` is high at rising edge t, `out_done` pulses for one cycle after edge t+1 when SERIAL=0, and after edge t+NW+1 when SERIAL=1. In the serial variant, `in_ready` is low from edge t until that pulse, and an `in_valid` in that window is ignored.
- R10: When negating, the +1 enters a word only if every lower-order word of the magnitude is zero. So -1.0 gives word 0 all ones and zero lower words, and -1.5 gives word 0 = 0xFFFFFFFFFFFFFFFE and word 1 = 0x8000000000000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Converter can take a value |
| in_data | input | 64 | binary64 input pattern |
| out_done | output | 1 | One-cycle strobe: result valid |
| out_words | output | 64*NW | Result words, word 0 in the top bits |
| out_ovf | output | 1 | Magnitude out of range |
| out_unf | output | 1 | Low-order bits were lost |
| out_inv | output | 1 | Input was NaN or infinity |

## Verification
The hardest case to reach is a negation whose carry must pass through a chain of zero low-order words while being stopped by a nonzero one. The stimulus therefore uses values whose magnitudes end exactly on word boundaries (-1.0, -2^62) next to values with bits in the middle word (-1.5, -1/3). It also compares every result against a plain wide negation computed in the bench. The range edges are reached with exponent-exact patterns: the largest double below 2^63 and 2^63 itself, and 2^-128, 2^-129 and a value with one stray bit below the lowest weight. Both output variants run in parallel on the same stimulus. A second value is offered while the serial variant is busy, to show that it is dropped.

// File: rtl/d2fx_pkg.sv
package d2fx_pkg;

  typedef enum logic [2:0] {
    FP_ZERO = 3'd0,
    FP_SUB  = 3'd1,
    FP_NORM = 3'd2,
    FP_INF  = 3'd3,
    FP_NAN  = 3'd4
  } fp_class_e;

  typedef struct packed {
    logic               sign;
    fp_class_e          cls;
    logic signed [12:0] exp;
    logic [52:0]        sig;
  } fp_fields_t;

  // one word of a negation: invert, then add the carry that the lower words allow
  function automatic logic [63:0] neg_word(input logic [63:0] w, input logic cin);
    return ~w + {63'd0, cin};
  endfunction

endpackage

// File: rtl/d2fx_unpack.sv
module d2fx_unpack
  import d2fx_pkg::*;
(
  input  logic [63:0] raw,
  output fp_fields_t  fld
);
  logic [10:0] e_fld;
  logic [51:0] f_fld;

  assign e_fld = raw[62:52];
  assign f_fld = raw[51:0];

  always_comb begin
    fld.sign = raw[63];
    fld.cls  = FP_NORM;
    fld.exp  = $signed({2'b00, e_fld}) - 13'sd1023;
    fld.sig  = {1'b1, f_fld};
    if (e_fld == 11'd0) begin
      fld.exp = -13'sd1022;
      fld.sig = {1'b0, f_fld};
      fld.cls = (f_fld == 52'd0) ? FP_ZERO : FP_SUB;
    end else if (e_fld == 11'h7FF) begin
      fld.exp = 13'sd0;
      fld.sig = 53'd0;
      fld.cls = (f_fld == 52'd0) ? FP_INF : FP_NAN;
    end
  end
endmodule

// File: rtl/d2fx_place.sv
module d2fx_place
  import d2fx_pkg::*;
#(
  parameter int NW = 3,
  parameter int KF = 2
) (
  input  fp_fields_t        fld,
  output logic [64*NW-1:0]  mag,
  output logic              ovf,
  output logic              unf
);
  localparam int W  = 64 * NW;
  localparam int XW = W + 53;
  localparam int SW = $clog2(XW);

  logic           finite;
  int             pos;
  int             dsh_i;
  logic [SW-1:0]  ushamt;
  logic [5:0]     dshamt;
  logic [XW-1:0]  up;
  logic [52:0]    kept;
  logic [52:0]    lost;

  assign finite = (fld.cls == FP_NORM) || (fld.cls == FP_SUB);
  // bit index that the significand LSB lands on inside the word vector
  assign pos    = int'(fld.exp) - 52 + 64 * KF;
  assign dsh_i  = -pos;

  always_comb begin
    mag    = '0;
    ovf    = 1'b0;
    unf    = 1'b0;
    up     = '0;
    kept   = '0;
    lost   = '0;
    ushamt = '0;
    dshamt = '0;
    if (finite) begin
      if (pos >= 0) begin
        if (pos >= W) begin
          ovf = |fld.sig;
        end else begin
          ushamt = SW'(pos);
          up     = {{(XW-53){1'b0}}, fld.sig} << ushamt;
          ovf    = |up[XW-1:W-1];
          mag    = up[W-1:0];
        end
      end else if (dsh_i > 53) begin
        unf = |fld.sig;
      end else begin
        dshamt = 6'(dsh_i);
        kept   = fld.sig >> dshamt;
        lost   = fld.sig & ~({53{1'b1}} << dshamt);
        unf    = |lost;
        mag    = {{(W-53){1'b0}}, kept};
      end
      if (ovf) mag = '0;
    end
  end
endmodule

// File: rtl/d2fx_emit.sv
module d2fx_emit
  import d2fx_pkg::*;
#(
  parameter int NW     = 3,
  parameter int SERIAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [64*NW-1:0] mag,
  input  logic             neg,
  input  logic [2:0]       flags_in,
  output logic [64*NW-1:0] words,
  output logic [2:0]       flags,
  output logic             done,
  output logic             busy
);
  localparam int W  = 64 * NW;
  localparam int IW = (NW > 1) ? $clog2(NW) : 1;

  generate
    if (SERIAL == 0) begin : g_par
      logic [63:0]  mw [NW];
      logic         zb [NW];
      logic [W-1:0] nvec;
      logic [W-1:0] words_q, words_d;
      logic [2:0]   flags_q, flags_d;
      logic         done_q;

      for (genvar i = 0; i < NW; i++) begin : g_w
        assign mw[i] = mag[W-1-64*i -: 64];
        if (i == NW-1) begin : g_lsw
          assign zb[i] = 1'b1;
        end else begin : g_up
          assign zb[i] = zb[i+1] & ~(|mw[i+1]);
        end
        assign nvec[W-1-64*i -: 64] = neg ? neg_word(mw[i], zb[i]) : mw[i];
      end

      always_comb begin
        words_d = words_q;
        flags_d = flags_q;
        if (start) begin
          words_d = nvec;
          flags_d = flags_in;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          words_q <= '0;
          flags_q <= '0;
          done_q  <= 1'b0;
        end else begin
          done_q <= start;
          if (start) begin
            words_q <= words_d;
            flags_q <= flags_d;
          end
        end
      end

      assign words = words_q;
      assign flags = flags_q;
      assign done  = done_q;
      assign busy  = 1'b0;
    end else begin : g_ser
      logic          busy_q, busy_d;
      logic [IW-1:0] idx_q, idx_d;
      logic [W-1:0]  mag_q, mag_d;
      logic          neg_q, neg_d;
      logic          zacc_q, zacc_d;
      logic [2:0]    hold_q, hold_d;
      logic [W-1:0]  words_q, words_d;
      logic [2:0]    flags_q, flags_d;
      logic          done_d, done_q;
      logic [63:0]   cur, outw;
      logic          en;

      always_comb begin
        cur = '0;
        for (int j = 0; j < NW; j++) begin
          if (int'(idx_q) == j) cur = mag_q[W-1-64*j -: 64];
        end
        outw = neg_q ? neg_word(cur, zacc_q) : cur;
      end

      always_comb begin
        busy_d  = busy_q;
        idx_d   = idx_q;
        mag_d   = mag_q;
        neg_d   = neg_q;
        zacc_d  = zacc_q;
        hold_d  = hold_q;
        words_d = words_q;
        flags_d = flags_q;
        done_d  = 1'b0;
        if (busy_q) begin
          for (int j = 0; j < NW; j++) begin
            if (int'(idx_q) == j) words_d[W-1-64*j -: 64] = outw;
          end
          zacc_d = zacc_q & ~(|cur);
          if (idx_q == '0) begin
            busy_d  = 1'b0;
            done_d  = 1'b1;
            flags_d = hold_q;
          end else begin
            idx_d = idx_q - 1'b1;
          end
        end else if (start) begin
          busy_d = 1'b1;
          idx_d  = IW'(NW - 1);
          mag_d  = mag;
          neg_d  = neg;
          zacc_d = 1'b1;
          hold_d = flags_in;
        end
      end

      assign en = busy_q | start;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy_q  <= 1'b0;
          idx_q   <= '0;
          mag_q   <= '0;
          neg_q   <= 1'b0;
          zacc_q  <= 1'b0;
          hold_q  <= '0;
          words_q <= '0;
          flags_q <= '0;
          done_q  <= 1'b0;
        end else begin
          done_q <= done_d;
          if (en) begin
            busy_q  <= busy_d;
            idx_q   <= idx_d;
            mag_q   <= mag_d;
            neg_q   <= neg_d;
            zacc_q  <= zacc_d;
            hold_q  <= hold_d;
            words_q <= words_d;
            flags_q <= flags_d;
          end
        end
      end

      assign words = words_q;
      assign flags = flags_q;
      assign done  = done_q;
      assign busy  = busy_q;

      // a serial result strobe never repeats on the next cycle
      assert_serial_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q)
        else $error("serial done strobe lasted more than one cycle");
    end
  endgenerate
endmodule

// File: rtl/d2fx_conv.sv
module d2fx_conv
  import d2fx_pkg::*;
#(
  parameter int NW     = 3,
  parameter int KF     = 2,
  parameter int SERIAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:0]      in_data,
  output logic             out_done,
  output logic [64*NW-1:0] out_words,
  output logic             out_ovf,
  output logic             out_unf,
  output logic             out_inv
);
  localparam int W = 64 * NW;

  logic [1:0]  rsync_q;
  logic        rst_i_n;
  logic        accept;
  logic        vld_q, vld_d;
  logic [63:0] data_q, data_d;
  fp_fields_t  fld;
  logic [W-1:0] mag;
  logic        p_ovf, p_unf, p_inv, p_neg;
  logic [2:0]  flg;
  logic        e_busy;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  assign in_ready = ~e_busy & ~((SERIAL != 0) & vld_q);
  assign accept   = in_valid & in_ready;

  always_comb begin
    vld_d  = accept;
    data_d = accept ? in_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (accept) data_q <= data_d;
    end
  end

  d2fx_unpack u_unpack (
    .raw (data_q),
    .fld (fld)
  );

  d2fx_place #(.NW(NW), .KF(KF)) u_place (
    .fld (fld),
    .mag (mag),
    .ovf (p_ovf),
    .unf (p_unf)
  );

  assign p_inv = (fld.cls == FP_INF) || (fld.cls == FP_NAN);
  assign p_neg = fld.sign & ~p_inv & ~p_ovf;
  assign flg   = {p_ovf, p_unf, p_inv};

  d2fx_emit #(.NW(NW), .SERIAL(SERIAL)) u_emit (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (vld_q),
    .mag      (mag),
    .neg      (p_neg),
    .flags_in (flg),
    .words    (out_words),
    .flags    ({out_ovf, out_unf, out_inv}),
    .done     (out_done),
    .busy     (e_busy)
  );

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({out_ovf, out_unf, out_inv}))
    else $error("more than one result flag set");

  assert_invalid_zero_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_done && out_inv) |-> (out_words == '0))
    else $error("invalid input produced nonzero words");

  assert_no_overflow_words_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_done && out_ovf) |-> (out_words == '0))
    else $error("overflow produced nonzero words");

  assert_busy_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    e_busy |-> !in_ready)
    else $error("ready while serial emission in progress");
endmodule

// File: tb/d2fx_conv_tb.sv
module d2fx_conv_tb;
  localparam int NW = 3;
  localparam int KF = 2;
  localparam int W  = 64 * NW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] in_data = '0;

  logic p_ready, p_done, p_ovf, p_unf, p_inv;
  logic s_ready, s_done, s_ovf, s_unf, s_inv;
  logic [W-1:0] p_words, s_words;

  int nvec = 0;
  int nfail = 0;
  int cycles = 0;
  bit finished = 0;

  logic [W-1:0] rp_words, rs_words;
  logic [2:0]   rp_flags, rs_flags;
  int           rp_lat, rs_lat;

  always #2.5 clk = ~clk;

  d2fx_conv #(.NW(NW), .KF(KF), .SERIAL(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(p_ready),
    .in_data(in_data), .out_done(p_done), .out_words(p_words),
    .out_ovf(p_ovf), .out_unf(p_unf), .out_inv(p_inv));

  d2fx_conv #(.NW(NW), .KF(KF), .SERIAL(1)) u_dut_ser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(s_ready),
    .in_data(in_data), .out_done(s_done), .out_words(s_words),
    .out_ovf(s_ovf), .out_unf(s_unf), .out_inv(s_inv));

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nfail++;
      $display("FAIL watchdog: run hung, got %0d cycles exp below 50000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // offer one value to both variants and collect their results
  task automatic run(input logic [63:0] x);
    bit pg = 0, sg = 0;
    while (!s_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (p_done && !pg) begin
        pg = 1; rp_lat = k; rp_words = p_words; rp_flags = {p_ovf, p_unf, p_inv};
      end
      if (s_done && !sg) begin
        sg = 1; rs_lat = k; rs_words = s_words; rs_flags = {s_ovf, s_unf, s_inv};
      end
      if (pg && sg) break;
    end
    if (!pg) begin rp_lat = 0; rp_words = 'x; rp_flags = 'x; end
    if (!sg) begin rs_lat = 0; rs_words = 'x; rs_flags = 'x; end
  endtask

  // flags are packed {ovf, unf, inv}
  task automatic expect_val(input string tag, input logic [63:0] x,
                            input logic [W-1:0] mag, input bit neg,
                            input logic [2:0] fl);
    logic [W-1:0] e;
    e = neg ? (~mag + 1'b1) : mag;
    run(x);
    chk({tag, " words par"}, rp_words, e);
    chk({tag, " words ser"}, rs_words, e);
    chk({tag, " flags par"}, W'(rp_flags), W'(fl));
    chk({tag, " flags ser"}, W'(rs_flags), W'(fl));
    chk({tag, " R9 latency par"}, W'(rp_lat), W'(2));
    chk({tag, " R9 latency ser"}, W'(rs_lat), W'(NW + 2));
  endtask

  task automatic t_reset_R1();
    chk("R1 done",  W'({p_done, s_done}), '0);
    chk("R1 flags", W'({p_ovf, p_unf, p_inv, s_ovf, s_unf, s_inv}), '0);
    chk("R1 words", p_words | s_words, '0);
    chk("R1 ready", W'({p_ready, s_ready}), W'(2'b11));
  endtask

  task automatic t_positive_R2();
    expect_val("R2 1.0",  64'h3FF0000000000000, W'(1) << 128, 0, 3'b000);
    expect_val("R2 1.5",  64'h3FF8000000000000, W'(3) << 127, 0, 3'b000);
    expect_val("R2 0.75", 64'h3FE8000000000000, W'(3) << 126, 0, 3'b000);
    expect_val("R2 third", 64'h3FD5555555555555, W'(53'h15555555555555) << 74, 0, 3'b000);
  endtask

  task automatic t_range_R3();
    expect_val("R3 2^62",  64'h43D0000000000000, W'(1) << 190, 0, 3'b000);
    expect_val("R3 below", 64'h43DFFFFFFFFFFFFF, W'(53'h1FFFFFFFFFFFFF) << 138, 0, 3'b000);
    expect_val("R3 2^63",  64'h43E0000000000000, '0, 0, 3'b100);
    expect_val("R3 -2^63", 64'hC3E0000000000000, '0, 0, 3'b100);
    expect_val("R3 huge",  64'h7FEFFFFFFFFFFFFF, '0, 0, 3'b100);
  endtask

  task automatic t_underflow_R4();
    expect_val("R4 2^-128", 64'h37F0000000000000, W'(1), 0, 3'b000);
    expect_val("R4 2^-129", 64'h37E0000000000000, '0, 0, 3'b010);
    expect_val("R4 stray",  64'h3AF0000000000001, W'(1) << 48, 0, 3'b010);
  endtask

  task automatic t_negate_R5();
    logic [W-1:0] a;
    expect_val("R5 -0.75",  64'hBFE8000000000000, W'(3) << 126, 1, 3'b000);
    expect_val("R5 -third", 64'hBFD5555555555555, W'(53'h15555555555555) << 74, 1, 3'b000);
    expect_val("R5 -2^-128", 64'hB7F0000000000000, W'(1), 1, 3'b000);
    run(64'h400921FB54442D18);
    a = rp_words;
    run(64'hC00921FB54442D18);
    chk("R5 x plus -x par", a + rp_words, '0);
    chk("R5 x plus -x ser", a + rs_words, '0);
  endtask

  task automatic t_zero_R6();
    expect_val("R6 +0", 64'h0000000000000000, '0, 0, 3'b000);
    expect_val("R6 -0", 64'h8000000000000000, '0, 0, 3'b000);
  endtask

  task automatic t_subnormal_R7();
    expect_val("R7 min sub", 64'h0000000000000001, '0, 0, 3'b010);
    expect_val("R7 max sub", 64'h800FFFFFFFFFFFFF, '0, 0, 3'b010);
  endtask

  task automatic t_invalid_R8();
    expect_val("R8 +inf", 64'h7FF0000000000000, '0, 0, 3'b001);
    expect_val("R8 -inf", 64'hFFF0000000000000, '0, 0, 3'b001);
    expect_val("R8 nan",  64'h7FF8000000000001, '0, 0, 3'b001);
  endtask

  task automatic t_busy_R9();
    int extra = 0;
    bit got = 0;
    while (!s_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 64'h3FF0000000000000;
    @(negedge clk);
    chk("R9 ready low while busy", W'(s_ready), '0);
    in_data = 64'h4000000000000000;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (s_done) begin
        if (!got) begin
          got = 1;
          chk("R9 busy input ignored", s_words, W'(1) << 128);
        end else extra++;
      end
      @(negedge clk);
    end
    chk("R9 one result only", W'({got, 8'(extra)}), W'({1'b1, 8'd0}));
  endtask

  task automatic t_carry_R10();
    expect_val("R10 -1.0",  64'hBFF0000000000000, W'(1) << 128, 1, 3'b000);
    chk("R10 -1.0 word0", rp_words[W-1 -: 64], 64'hFFFFFFFFFFFFFFFF);
    expect_val("R10 -1.5",  64'hBFF8000000000000, W'(3) << 127, 1, 3'b000);
    chk("R10 -1.5 word0", rs_words[W-1 -: 64], 64'hFFFFFFFFFFFFFFFE);
    chk("R10 -1.5 word1", rs_words[W-65 -: 64], 64'h8000000000000000);
    expect_val("R10 -2^62", 64'hC3D0000000000000, W'(1) << 190, 1, 3'b000);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_R1();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_R1();
    t_positive_R2();
    t_range_R3();
    t_underflow_R4();
    t_negate_R5();
    t_zero_R6();
    t_subnormal_R7();
    t_invalid_R8();
    t_busy_R9();
    t_carry_R10();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule